// File: doc/BRIEF.md
# Power-line PHY frame bit assembler

This block produces the uncoded bit stream of one power-line PHY frame, the part that follows the training symbols. A frame request carries a transmit mode number and a payload length. Once the request is accepted, the block emits bits in a fixed order: an 11-bit synchronisation word, then a 12-bit header, then the payload, then six zero tail bits when the mode calls for them. The header holds the mode number, one reserved zero and six zero header tail bits. The payload bits arrive on a valid/ready stream and pass through in order.

Each emitted bit carries a segment tag, the forward-error-correction family that must encode it (repetition or convolutional) and the code-rate denominator. A reinitialise strobe marks the bits at which the downstream convolutional encoder must start again from the zero state. A request with a reserved mode number or an out-of-range length is refused. The refusal raises a one-cycle error flag and produces no bits. Outputs are registered, so each bit appears one cycle after the edge that produces it.

Top module: `plc_frame_bitgen`

## Requirements
- R1: After reset, `out_valid`, `out_init` and `req_err` are low and `req_ready` is high.
- R2: The first 11 bits of a frame are 1,1,1,0,0,0,1,0,0,1,0, in that order: the value 0x247 sent least significant bit first. They carry segment code 0, FEC code 0 (repetition) and rate 8.
- R3: The next 12 bits are the five mode bits, least significant first, followed by seven zeros. They carry segment code 1, FEC code 1 (convolutional) and rate 8.
- R4: The L payload bits follow in arrival order with segment code 2. A payload bit is taken only in a cycle where `pay_valid` and `pay_ready` are both high. In any other cycle during the payload the frame does not advance.
- R5: For modes 0 to 15 the payload uses FEC code 1, and six zero bits with segment code 3 follow it. The frame is L+29 bits in total.
- R6: For modes 16 to 20 the payload uses FEC code 0 and no tail follows. The frame is L+23 bits in total.
- R7: The rate on payload and tail bits follows the mode. Modes 0 and 2 use 8, mode 1 uses 7, mode 3 uses 6 and mode 4 uses 5. Modes 5, 6 and 9 use 3, and modes 7, 8 and 10 to 15 use 2. Modes 16 and 17 use 8 and 7, modes 18 and 20 use 5, and mode 19 uses 7.
- R8: `out_init` is high with the first header bit and with the first payload bit, and with no other bit.
- R9: A request whose mode is 21 to 31 raises `req_err` for one cycle and emits no bit.
- R10: A request whose length is below 96 or above 2152 raises `req_err` for one cycle and emits no bit.
- R11: While a frame is in progress `req_ready` is low, and a request presented then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Frame request strobe |
| req_ready | output | 1 | High when a request can be taken |
| req_mode | input | 5 | Transmit mode number |
| req_len | input | 12 | Payload length in bits |
| req_err | output | 1 | One-cycle pulse on a refused request |
| pay_valid | input | 1 | Payload bit available |
| pay_ready | output | 1 | Payload bit will be taken |
| pay_bit | input | 1 | Payload bit |
| out_valid | output | 1 | Emitted bit is valid |
| out_bit | output | 1 | Emitted bit |
| out_seg | output | 2 | Segment: 0 sync, 1 header, 2 payload, 3 tail |
| out_fec | output | 1 | FEC family: 0 repetition, 1 convolutional |
| out_rate | output | 4 | Code-rate denominator |
| out_init | output | 1 | Encoder restart marker on this bit |

## Verification
The hardest situation to reach is a payload segment that stalls at arbitrary points, including on its first and last bits. A stall there must not duplicate, drop or mis-tag a bit, and it must not move the restart marker or the tail. The stimulus withholds `pay_valid` in about a quarter of payload cycles, chosen at random, across every mode 0 to 20 and at both length limits. It also presents a second request partway through a frame, which must leave that frame unchanged.

// File: rtl/plc_fbg_pkg.sv
package plc_fbg_pkg;
  localparam int MODE_W    = 5;
  localparam int RATE_W    = 4;
  localparam int SYNC_BITS = 11;
  localparam int HDR_BITS  = 12;
  localparam int TAIL_BITS = 6;
  localparam int MODE_LAST = 20;
  localparam int REP_FROM  = 16;
  localparam logic [SYNC_BITS-1:0] SYNC_WORD = 11'h247;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_HDR  = 2'd1,
    SEG_DATA = 2'd2,
    SEG_TAIL = 2'd3
  } seg_t;

  typedef enum logic {
    FEC_REP  = 1'b0,
    FEC_CONV = 1'b1
  } fec_t;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return int'(m) <= MODE_LAST;
  endfunction

  function automatic logic mode_rep(input logic [MODE_W-1:0] m);
    return int'(m) >= REP_FROM;
  endfunction

  function automatic logic [RATE_W-1:0] mode_rate(input logic [MODE_W-1:0] m);
    logic [RATE_W-1:0] r;
    case (m)
      5'd0, 5'd2, 5'd16:        r = 4'd8;
      5'd1, 5'd17, 5'd19:       r = 4'd7;
      5'd3:                     r = 4'd6;
      5'd4, 5'd18, 5'd20:       r = 4'd5;
      5'd5, 5'd6, 5'd9:         r = 4'd3;
      default:                  r = 4'd2;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/plc_fbg_req_check.sv
module plc_fbg_req_check
  import plc_fbg_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int LEN_MIN = 96,
  parameter int LEN_MAX = 2152
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [LEN_W-1:0]  len,
  output logic              ok,
  output logic              rep,
  output logic [RATE_W-1:0] rate
);
  logic len_in;
  always_comb begin
    len_in = (int'(len) >= LEN_MIN) && (int'(len) <= LEN_MAX);
    ok     = len_in && mode_legal(mode);
    rep    = mode_rep(mode);
    rate   = mode_rate(mode);
  end
endmodule

// File: rtl/plc_fbg_seq.sv
module plc_fbg_seq
  import plc_fbg_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             rep,
  input  logic             pay_valid,
  output logic             busy,
  output logic             pay_ready,
  output logic             emit,
  output seg_t             seg,
  output logic [LEN_W-1:0] idx
);
  logic busy_q;
  seg_t seg_q;
  logic [LEN_W-1:0] idx_q;
  logic seg_last;

  always_comb begin
    case (seg_q)
      SEG_SYNC: seg_last = idx_q == LEN_W'(SYNC_BITS - 1);
      SEG_HDR:  seg_last = idx_q == LEN_W'(HDR_BITS - 1);
      SEG_DATA: seg_last = idx_q == len - LEN_W'(1);
      default:  seg_last = idx_q == LEN_W'(TAIL_BITS - 1);
    endcase
    pay_ready = busy_q && (seg_q == SEG_DATA);
    emit      = busy_q && ((seg_q != SEG_DATA) || pay_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      seg_q  <= SEG_SYNC;
      idx_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      seg_q  <= SEG_SYNC;
      idx_q  <= '0;
    end else if (emit) begin
      if (seg_last) begin
        idx_q <= '0;
        case (seg_q)
          SEG_SYNC: seg_q <= SEG_HDR;
          SEG_HDR:  seg_q <= SEG_DATA;
          SEG_DATA: begin
            if (rep) busy_q <= 1'b0;
            else     seg_q  <= SEG_TAIL;
          end
          default:  busy_q <= 1'b0;
        endcase
      end else begin
        idx_q <= idx_q + LEN_W'(1);
      end
    end
  end

  assign busy = busy_q;
  assign seg  = seg_q;
  assign idx  = idx_q;

  p_hold_on_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_ready && !pay_valid) |=> ($stable(idx_q) && $stable(seg_q)));
  p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
endmodule

// File: rtl/plc_fbg_emit.sv
module plc_fbg_emit
  import plc_fbg_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  seg_t              seg,
  input  logic [LEN_W-1:0]  idx,
  input  logic [MODE_W-1:0] mode,
  input  logic              rep,
  input  logic [RATE_W-1:0] rate,
  input  logic              pay_bit,
  output logic              o_valid,
  output logic              o_bit,
  output seg_t              o_seg,
  output fec_t              o_fec,
  output logic [RATE_W-1:0] o_rate,
  output logic              o_init
);
  logic              nx_bit;
  fec_t              nx_fec;
  logic [RATE_W-1:0] nx_rate;
  logic              nx_init;
  logic              first;

  always_comb begin
    first   = idx == '0;
    nx_bit  = 1'b0;
    nx_fec  = FEC_CONV;
    nx_rate = rate;
    case (seg)
      SEG_SYNC: begin
        nx_bit  = SYNC_WORD[idx[3:0]];
        nx_fec  = FEC_REP;
        nx_rate = RATE_W'(8);
      end
      SEG_HDR: begin
        nx_bit  = (int'(idx) < MODE_W) ? mode[idx[2:0]] : 1'b0;
        nx_rate = RATE_W'(8);
      end
      SEG_DATA: begin
        nx_bit = pay_bit;
        nx_fec = rep ? FEC_REP : FEC_CONV;
      end
      default: nx_bit = 1'b0;
    endcase
    nx_init = first && ((seg == SEG_HDR) || (seg == SEG_DATA));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_bit   <= 1'b0;
      o_seg   <= SEG_SYNC;
      o_fec   <= FEC_REP;
      o_rate  <= '0;
      o_init  <= 1'b0;
    end else begin
      o_valid <= emit;
      o_init  <= emit && nx_init;
      if (emit) begin
        o_bit  <= nx_bit;
        o_seg  <= seg;
        o_fec  <= nx_fec;
        o_rate <= nx_rate;
      end
    end
  end

  p_sync_rep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_seg == SEG_SYNC) |-> (o_fec == FEC_REP && o_rate == RATE_W'(8)));
  p_hdr_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_seg == SEG_HDR) |-> (o_fec == FEC_CONV && o_rate == RATE_W'(8)));
  p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_seg == SEG_TAIL) |-> (!o_bit && o_fec == FEC_CONV));
  p_init_place_r8: assert property (@(posedge clk) disable iff (!rst_n)
    o_init |-> (o_valid && (o_seg == SEG_HDR || o_seg == SEG_DATA)));
endmodule

// File: rtl/plc_frame_bitgen.sv
module plc_frame_bitgen
  import plc_fbg_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int LEN_MIN = 96,
  parameter int LEN_MAX = 2152
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [MODE_W-1:0]    req_mode,
  input  logic [LEN_W-1:0]     req_len,
  output logic                 req_err,
  input  logic                 pay_valid,
  output logic                 pay_ready,
  input  logic                 pay_bit,
  output logic                 out_valid,
  output logic                 out_bit,
  output logic [1:0]           out_seg,
  output logic                 out_fec,
  output logic [RATE_W-1:0]    out_rate,
  output logic                 out_init
);
  logic              chk_ok, chk_rep;
  logic [RATE_W-1:0] chk_rate;
  logic              busy, emit, start_evt, refuse_evt;
  seg_t              seg;
  logic [LEN_W-1:0]  idx;
  logic [MODE_W-1:0] mode_q;
  logic [LEN_W-1:0]  len_q;
  logic              rep_q;
  logic [RATE_W-1:0] rate_q;
  logic              err_q;
  seg_t              o_seg;
  fec_t              o_fec;

  plc_fbg_req_check #(.LEN_W(LEN_W), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_check (
    .mode(req_mode), .len(req_len), .ok(chk_ok), .rep(chk_rep), .rate(chk_rate)
  );

  assign start_evt  = req_valid && !busy && chk_ok;
  assign refuse_evt = req_valid && !busy && !chk_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      len_q  <= '0;
      rep_q  <= 1'b0;
      rate_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= refuse_evt;
      if (start_evt) begin
        mode_q <= req_mode;
        len_q  <= req_len;
        rep_q  <= chk_rep;
        rate_q <= chk_rate;
      end
    end
  end

  plc_fbg_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .len(len_q), .rep(rep_q),
    .pay_valid(pay_valid), .busy(busy), .pay_ready(pay_ready), .emit(emit),
    .seg(seg), .idx(idx)
  );

  plc_fbg_emit #(.LEN_W(LEN_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .emit(emit), .seg(seg), .idx(idx), .mode(mode_q),
    .rep(rep_q), .rate(rate_q), .pay_bit(pay_bit), .o_valid(out_valid),
    .o_bit(out_bit), .o_seg(o_seg), .o_fec(o_fec), .o_rate(out_rate),
    .o_init(out_init)
  );

  assign req_ready = !busy;
  assign req_err   = err_q;
  assign out_seg   = o_seg;
  assign out_fec   = o_fec;

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!out_valid && req_ready));
  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> (!out_valid));
  p_rep_no_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_seg == SEG_TAIL) |-> !rep_q);
  p_data_fec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_seg == SEG_DATA) |-> (o_fec == (rep_q ? FEC_REP : FEC_CONV)));
endmodule

// File: tb/plc_frame_bitgen_tb_top.sv
module plc_frame_bitgen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [4:0] req_mode = '0;
  logic [11:0] req_len = '0;
  logic pay_valid = 1'b0;
  logic pay_bit = 1'b0;
  logic req_ready, req_err, pay_ready, out_valid, out_bit, out_fec, out_init;
  logic [1:0] out_seg;
  logic [3:0] out_rate;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit pbits [2152];

  always #10 clk = ~clk;

  plc_frame_bitgen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_len(req_len), .req_err(req_err),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_bit(pay_bit),
    .out_valid(out_valid), .out_bit(out_bit), .out_seg(out_seg),
    .out_fec(out_fec), .out_rate(out_rate), .out_init(out_init)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int exp_rate(input int m);
    if (m >= 16) return (m == 16) ? 8 : ((m == 18 || m == 20) ? 5 : 7);
    if (m == 0 || m == 2) return 8;
    if (m == 1) return 7;
    if (m == 3) return 6;
    if (m == 4) return 5;
    if (m == 5 || m == 6 || m == 9) return 3;
    return 2;
  endfunction

  function automatic int exp_seg(input int i, input int L);
    if (i < 11) return 0;
    if (i < 23) return 1;
    if (i < 23 + L) return 2;
    return 3;
  endfunction

  function automatic bit exp_bit(input int i, input int m, input int L);
    bit [10:0] sy;
    sy = {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    if (i < 11) return sy[i];
    if (i < 16) return m[i - 11];
    if (i < 23) return 1'b0;
    if (i < 23 + L) return pbits[i - 23];
    return 1'b0;
  endfunction

  task automatic run_frame(input int m, input int L, input bit poke);
    int cnt = 0, pidx = 0, bad_bit = 0, bad_seg = 0, bad_fec = 0, bad_rate = 0, bad_init = 0;
    int first_bad = -1;
    bit dv = 0, dr = 0, ready_lo = 0;
    int total;
    int xfec;
    int xrate;
    int quiet;
    for (int k = 0; k < L; k++) pbits[k] = bit'($urandom % 2);
    total = (m >= 16) ? L + 23 : L + 29;
    @(negedge clk);
    req_valid = 1'b1; req_mode = 5'(m); req_len = 12'(L);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err == 1'b0, "R9 legal request not refused", int'(req_err), 0);
    ready_lo = !req_ready;
    chk(ready_lo, "R11 ready low during frame", int'(req_ready), 0);
    for (int c = 0; c < 20000; c++) begin
      if (dv && dr) pidx++;
      if (out_valid) begin
        xfec  = (exp_seg(cnt, L) == 0) ? 0 : ((exp_seg(cnt, L) == 2 && m >= 16) ? 0 : 1);
        xrate = (exp_seg(cnt, L) < 2) ? 8 : exp_rate(m);
        if (out_bit != exp_bit(cnt, m, L)) begin bad_bit++; if (first_bad < 0) first_bad = cnt; end
        if (int'(out_seg) != exp_seg(cnt, L)) bad_seg++;
        if (int'(out_fec) != xfec) bad_fec++;
        if (int'(out_rate) != xrate) bad_rate++;
        if (out_init != (cnt == 11 || cnt == 23)) bad_init++;
        cnt++;
      end
      if (req_ready) break;
      pay_valid = ($urandom % 4) != 0;
      pay_bit = (pidx < 2152) ? pbits[pidx] : 1'b0;
      dv = pay_valid; dr = pay_ready;
      if (poke) begin
        if (c == 40) begin req_valid = 1'b1; req_mode = 5'd3; req_len = 12'd100; end
        if (c == 41) req_valid = 1'b0;
      end
      @(negedge clk);
    end
    pay_valid = 1'b0;
    req_valid = 1'b0;
    chk(cnt == total, (m >= 16) ? "R6 frame length L+23" : "R5 frame length L+29", cnt, total);
    chk(bad_bit == 0, "R2/R3/R4 bit values (first bad index in actual)", first_bad, -1);
    chk(bad_seg == 0, "R4 segment tags", bad_seg, 0);
    chk(bad_fec == 0, (m >= 16) ? "R6 fec codes" : "R5 fec codes", bad_fec, 0);
    chk(bad_rate == 0, "R7 rate per mode", bad_rate, 0);
    chk(bad_init == 0, "R8 init strobe placement", bad_init, 0);
    if (poke) begin
      quiet = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (out_valid || !req_ready) quiet++;
      end
      chk(quiet == 0, "R11 mid-frame request ignored", quiet, 0);
    end
  endtask

  task automatic run_bad(input int m, input int L, input string req);
    int noisy = 0;
    @(negedge clk);
    req_valid = 1'b1; req_mode = 5'(m); req_len = 12'(L);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err == 1'b1, req, int'(req_err), 1);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (out_valid || !req_ready || req_err) noisy++;
    end
    chk(noisy == 0, req, noisy, 0);
  endtask

  initial begin
    void'($urandom(32'd20240601));
    #5;
    chk(out_valid == 1'b0 && out_init == 1'b0 && req_err == 1'b0, "R1 outputs quiet in reset",
        int'(out_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && out_valid == 1'b0, "R1 idle after reset", int'(req_ready), 1);
    for (int m = 0; m <= 20; m++) run_frame(m, 96 + int'($urandom % 200), 1'b0);
    run_frame(0, 96, 1'b0);
    run_frame(15, 2152, 1'b0);
    run_frame(16, 2152, 1'b0);
    run_frame(20, 96, 1'b0);
    run_frame(7, 300, 1'b1);
    run_frame(18, 200, 1'b1);
    run_bad(21, 200, "R9 mode 21 refused");
    run_bad(31, 500, "R9 mode 31 refused");
    run_bad(4, 95, "R10 length 95 refused");
    run_bad(17, 2153, "R10 length 2153 refused");
    run_bad(0, 0, "R10 length 0 refused");
    for (int k = 0; k < 20; k++) run_frame(int'($urandom % 21), 96 + int'($urandom % 400), 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule